// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block collects up to eight asynchronous interrupt pins from outside the chip and turns them into interrupt requests. Each pin is synchronized and watched by its own detector. Software picks, for each pin, whether a falling edge, a rising edge, either edge, a low level or a high level counts as an event. An event latches a pending flag. The flag raises the pin's interrupt output when the pin is unmasked and its priority field is non-zero. A combined output ORs every pin's request, for systems that route all pins to one parent line.

Software reaches the block through a plain synchronous register port. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. Across the sense, priority and pending-flag registers, pin 0 always sits in the most significant field. Masking has two write-only registers, one that sets mask bits and one that clears them. Pending flags are cleared by writing zeros.

Each pin's detector is a two-state machine. PS_IDLE moves to PS_PENDING on the "detect" transition, when the selected edge or level is seen. PS_PENDING returns to PS_IDLE on the "software clear" transition, when the flag-clearing register is written with a 0 in that pin's bit. PS_PENDING otherwise holds. In PS_IDLE a clear write has no effect.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, every sense and priority field reads 0, all pending flags read 0, every pin is masked, and `irq_out` and `irq_any` are low.
- R2: The sense register is at address 0. Pin n's field is `SENSE_W` bits wide, starting at bit 32-(n+1)*`SENSE_W`. It reads back what was written.
- R3: The priority register is at address 1. Pin n's 4-bit field starts at bit 32-(n+1)*4 and reads back what was written. A field of 0 keeps the pin's output low, and any non-zero value lets it through.
- R4: The pending-flag register is at address 2. It is `SRC_W` bits wide (8 or 32), with pin n at bit `SRC_W`-1-n.
- R5: Writing address 2 clears each pending flag whose bit is 0 and leaves flags whose bit is 1 unchanged.
- R6: Writing 1 to a pin's bit at address 3 masks that pin, and writing 1 at address 4 unmasks it. Zero bits have no effect, both registers use the bit order of R4, and both read as 0.
- R7: Edge codes are 0 (falling), 1 (rising) and 4 (both edges). The selected edge sets the pending flag 3 clock edges after the pin changes, and the flag stays set until software clears it.
- R8: Level codes are 2 (active low) and 3 (active high). While the pin is at its active level the flag is set. If the level is still active when the flag is cleared, the flag sets again on the next edge.
- R9: Sense codes 5 to 15 are reserved and never set a pending flag.
- R10: `irq_out[n]` is high exactly when pin n is pending, unmasked and has a non-zero priority field. `irq_any` is the OR of all `irq_out` bits.
- R11: The mode register is at address 5. Only bit 23, which selects individual-pin mode, is stored, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| irq_out | output | NUM_PINS | Per-pin interrupt requests |
| irq_any | output | 1 | OR of all per-pin requests |

## Verification
A detector stuck in the wrong state shows up in the pending-flag register on the first read after the expected edge. That read comes three edges after the pin moves, or one edge after a clear. A wrong mask or priority bit shows up on `irq_out` and `irq_any` in the same cycle as the register write that should have changed it. The error is combinational, so there is no delay to wait out. A misplaced field position sends a pin's event to another pin's flag bit, which the first pending-flag read exposes.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned PRIO_W   = 4;
    localparam int unsigned MODE_BIT = 23;

    localparam logic [ADDR_W-1:0] RA_SENSE  = 3'd0;
    localparam logic [ADDR_W-1:0] RA_PRIO   = 3'd1;
    localparam logic [ADDR_W-1:0] RA_SOURCE = 3'd2;
    localparam logic [ADDR_W-1:0] RA_MSET   = 3'd3;
    localparam logic [ADDR_W-1:0] RA_MCLR   = 3'd4;
    localparam logic [ADDR_W-1:0] RA_MODE   = 3'd5;

    localparam logic [3:0] SNS_FALL = 4'd0;
    localparam logic [3:0] SNS_RISE = 4'd1;
    localparam logic [3:0] SNS_LOW  = 4'd2;
    localparam logic [3:0] SNS_HIGH = 4'd3;
    localparam logic [3:0] SNS_BOTH = 4'd4;

    typedef enum logic {
        PS_IDLE    = 1'b0,
        PS_PENDING = 1'b1
    } pin_state_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/extirq_pin.sv
module extirq_pin
    import extirq_pkg::*;
#(
    parameter int SENSE_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_async,
    input  logic [SENSE_W-1:0] sense,
    input  logic               clr,
    output logic               pending
);
    logic       lvl;
    logic       lvl_d;
    logic       rise;
    logic       fall;
    logic       hit;
    logic [3:0] code;
    pin_state_e state_q;
    pin_state_e state_d;

    extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_async),
        .q     (lvl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d <= 1'b0;
        end else begin
            lvl_d <= lvl;
        end
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;
    assign code = 4'(sense);

    always_comb begin
        case (code)
            SNS_FALL: hit = fall;
            SNS_RISE: hit = rise;
            SNS_LOW:  hit = ~lvl;
            SNS_HIGH: hit = lvl;
            SNS_BOTH: hit = rise | fall;
            default:  hit = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: detect moves to pending, software clear returns to idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:    if (hit) state_d = PS_PENDING;
            PS_PENDING: if (clr) state_d = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pending = (state_q == PS_PENDING);
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PENDING && !clr) |=> (state_q == PS_PENDING));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PENDING && clr) |=> (state_q == PS_IDLE));

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && code > SNS_BOTH) |=> (state_q == PS_IDLE));
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8,
    parameter bit HAS_MODE = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]         pending,
    output logic [NUM_PINS*SENSE_W-1:0] sense_flat,
    output logic [NUM_PINS-1:0]         prio_on,
    output logic [NUM_PINS-1:0]         mask,
    output logic [NUM_PINS-1:0]         clr
);
    logic [NUM_PINS*PRIO_W-1:0] prio_flat;
    logic [NUM_PINS-1:0]        wbits;
    logic                       wr_sense, wr_prio, wr_src, wr_mset, wr_mclr, wr_mode;
    logic                       mode_bit;
    logic [REG_W-1:0]           sense_img, prio_img, src_img, mode_img;

    assign wr_sense = bus_wr && (bus_addr == RA_SENSE);
    assign wr_prio  = bus_wr && (bus_addr == RA_PRIO);
    assign wr_src   = bus_wr && (bus_addr == RA_SOURCE);
    assign wr_mset  = bus_wr && (bus_addr == RA_MSET);
    assign wr_mclr  = bus_wr && (bus_addr == RA_MCLR);
    assign wr_mode  = bus_wr && (bus_addr == RA_MODE);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam int SPOS = REG_W - (g + 1) * SENSE_W;
        localparam int PPOS = REG_W - (g + 1) * PRIO_W;
        localparam int BPOS = SRC_W - 1 - g;

        logic [SENSE_W-1:0] sense_r;
        logic [PRIO_W-1:0]  prio_r;
        logic               mask_r;

        assign wbits[g] = bus_wdata[BPOS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sense_r <= '0;
                prio_r  <= '0;
                mask_r  <= 1'b1;
            end else begin
                if (wr_sense) sense_r <= bus_wdata[SPOS +: SENSE_W];
                if (wr_prio)  prio_r  <= bus_wdata[PPOS +: PRIO_W];
                if (wr_mset && wbits[g]) begin
                    mask_r <= 1'b1;
                end else if (wr_mclr && wbits[g]) begin
                    mask_r <= 1'b0;
                end
            end
        end

        assign sense_flat[g*SENSE_W +: SENSE_W] = sense_r;
        assign prio_flat[g*PRIO_W +: PRIO_W]    = prio_r;
        assign prio_on[g]                       = |prio_r;
        assign mask[g]                          = mask_r;
        assign clr[g]                           = wr_src && !wbits[g];
    end

    if (HAS_MODE) begin : g_mode
        logic mode_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_r <= 1'b0;
            end else if (wr_mode) begin
                mode_r <= bus_wdata[MODE_BIT];
            end
        end
        assign mode_bit = mode_r;
    end else begin : g_no_mode
        assign mode_bit = 1'b0;
    end

    always_comb begin
        sense_img = '0;
        prio_img  = '0;
        src_img   = '0;
        mode_img  = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            sense_img[REG_W - (i + 1) * SENSE_W +: SENSE_W] = sense_flat[i*SENSE_W +: SENSE_W];
            prio_img[REG_W - (i + 1) * PRIO_W +: PRIO_W]    = prio_flat[i*PRIO_W +: PRIO_W];
            src_img[SRC_W - 1 - i]                          = pending[i];
        end
        mode_img[MODE_BIT] = mode_bit;
    end

    always_comb begin
        case (bus_addr)
            RA_SENSE:  bus_rdata = sense_img;
            RA_PRIO:   bus_rdata = prio_img;
            RA_SOURCE: bus_rdata = src_img;
            RA_MODE:   bus_rdata = mode_img;
            default:   bus_rdata = '0;
        endcase
    end

    p_mset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask & $past(wbits)) == $past(wbits)));

    p_mclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask & $past(wbits)) == '0));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_mset || wr_mclr) |=> $stable(mask));
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SENSE_W     = 4,
    parameter int SRC_W       = 8,
    parameter bit HAS_MODE    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [2:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] irq_out,
    output logic                irq_any
);
    logic [NUM_PINS*SENSE_W-1:0] sense_flat;
    logic [NUM_PINS-1:0]         prio_on;
    logic [NUM_PINS-1:0]         mask;
    logic [NUM_PINS-1:0]         clr;
    logic [NUM_PINS-1:0]         pending;

    extirq_regs #(
        .NUM_PINS (NUM_PINS),
        .SENSE_W  (SENSE_W),
        .SRC_W    (SRC_W),
        .HAS_MODE (HAS_MODE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pending    (pending),
        .sense_flat (sense_flat),
        .prio_on    (prio_on),
        .mask       (mask),
        .clr        (clr)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_det
        extirq_pin #(
            .SENSE_W     (SENSE_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[g]),
            .sense     (sense_flat[g*SENSE_W +: SENSE_W]),
            .clr       (clr[g]),
            .pending   (pending[g])
        );
    end

    assign irq_out = pending & ~mask & prio_on;
    assign irq_any = |irq_out;

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_any);

    p_needs_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (|pending));
endmodule

// File: tb/sim_extirq_ctrl.sv
module sim_extirq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;

    typedef struct packed {
        logic [3:0] code;
        logic       v0;
        logic       v1;
        logic       e1;
        logic       e2;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'd0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'd1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd4, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'd4, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'd2, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'd2, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'd2, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'd3, 1'b0, 1'b1, 1'b1, 1'b1},
        '{4'd3, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd5, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'd15, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [31:0]   bus_wdata = 32'd0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] irq_out;
    logic          irq_any;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    extirq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .irq_out   (irq_out),
        .irq_any   (irq_any)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string vec_tag(input logic [3:0] c);
        if (c == 4'd0 || c == 4'd1 || c == 4'd4) return "R7";
        if (c == 4'd2 || c == 4'd3) return "R8";
        return "R9";
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        bus_read(3'd0, rd); check("R1 sense reset", rd, 32'h0);
        bus_read(3'd1, rd); check("R1 prio reset", rd, 32'h0);
        bus_read(3'd2, rd); check("R1 source reset", rd, 32'h0);
        check("R1 irq_out reset", {23'd0, irq_any, irq_out}, 32'h0);

        // R11 mode register
        bus_write(3'd5, 32'hFFFF_FFFF);
        bus_read(3'd5, rd); check("R11 mode bit only", rd, 32'h0080_0000);
        bus_write(3'd5, 32'h0);
        bus_read(3'd5, rd); check("R11 mode cleared", rd, 32'h0);

        // R2 / R3 readback
        bus_write(3'd0, 32'h0123_4567);
        bus_read(3'd0, rd); check("R2 sense readback", rd, 32'h0123_4567);
        bus_write(3'd1, 32'h89AB_CDEF);
        bus_read(3'd1, rd); check("R3 prio readback", rd, 32'h89AB_CDEF);
        bus_write(3'd1, 32'h0);

        // pin 5 rising (field at bit 8), others falling with pins low
        bus_write(3'd0, 32'h0000_0100);
        bus_write(3'd2, 32'h0);
        @(negedge clk);
        pin_in[5] = 1'b1;
        bus_read(3'd2, rd); check("R7 not yet pending after 1 edge", rd, 32'h0);
        idle(5);
        bus_read(3'd2, rd); check("R4 pin5 at bit2", rd, 32'h0000_0004);
        check("R1 masked after reset", {24'd0, irq_out}, 32'h0);

        bus_write(3'd4, 32'h0000_0004);
        check("R3 prio zero blocks", {24'd0, irq_out}, 32'h0);
        bus_write(3'd1, 32'h0000_0F00);
        check("R10 irq_out pin5", {24'd0, irq_out}, 32'h0000_0020);
        check("R10 irq_any", {31'd0, irq_any}, 32'h1);
        bus_write(3'd1, 32'h0000_0100);
        check("R3 nonzero prio passes", {24'd0, irq_out}, 32'h0000_0020);
        bus_write(3'd3, 32'h0);
        check("R6 zero mask write no effect", {24'd0, irq_out}, 32'h0000_0020);
        bus_read(3'd3, rd); check("R6 mask-set reads 0", rd, 32'h0);
        bus_read(3'd4, rd); check("R6 mask-clear reads 0", rd, 32'h0);
        bus_write(3'd3, 32'h0000_0004);
        check("R6 mask set", {23'd0, irq_any, irq_out}, 32'h0);
        bus_write(3'd4, 32'h0000_0004);
        check("R6 mask clear", {24'd0, irq_out}, 32'h0000_0020);

        // R5 clearing
        bus_write(3'd2, 32'h0000_00FF);
        bus_read(3'd2, rd); check("R5 write one keeps flag", rd, 32'h0000_0004);
        bus_write(3'd2, 32'h0000_00FB);
        bus_read(3'd2, rd); check("R5 write zero clears", rd, 32'h0);
        check("R10 output drops with flag", {23'd0, irq_any, irq_out}, 32'h0);

        // table walk on pin 2 (sense field at bit 20, flag at bit 5)
        for (int k = 0; k < NVEC; k++) begin
            bus_write(3'd0, 32'h0070_0100);
            pin_in[2] = VECS[k].v0;
            idle(6);
            bus_write(3'd2, 32'h0);
            bus_write(3'd0, 32'h0000_0100 | ({28'd0, VECS[k].code} << 20));
            pin_in[2] = VECS[k].v1;
            idle(6);
            bus_read(3'd2, rd);
            check($sformatf("%s vec%0d after change", vec_tag(VECS[k].code), k),
                  rd & 32'h20, {26'd0, VECS[k].e1, 5'd0});
            bus_write(3'd2, 32'h0);
            idle(3);
            bus_read(3'd2, rd);
            check($sformatf("%s vec%0d after clear", vec_tag(VECS[k].code), k),
                  rd & 32'h20, {26'd0, VECS[k].e2, 5'd0});
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule